// File: doc/BRIEF.md
# Lamp Ageing Window Detector with Re-lamp Sensing

This block watches a digitized lamp-sense sample, given as an unsigned millivolt code, and decides when the lamp has reached end of life. The sample is compared with a window. The window center is either a fixed 2500 mV level or a second input that follows a voltage proportional to the supply bus. The half-width of the window is either 220 mV or 720 mV. A two-bit configuration code chooses the center and the width independently. The window check only runs during the run phase. During ignition it is blanked.

A window violation does not raise the fault at once. It starts a filter timer that has two parts: a charge interval followed by a decay interval. The violation must persist through the whole charge interval and must be present again at the last cycle of the decay interval. Only then is the fault latched. Once set, the fault stays high until an explicit clear or a re-lamp event.

A second comparator on the same sample detects that the lamp is missing. It sets above 4630 mV and releases below 4470 mV. When a missing lamp is released, the block emits a one-cycle re-lamp pulse, and that pulse also wipes the latched fault.

Top module: `eol_window_monitor`

## Requirements
- R1: While the window check is active, a sample strictly above the upper limit or strictly below the lower limit counts as a violation. A sample equal to either limit is inside the window.
- R2: Configuration bit 0 selects the center. 0 selects the fixed 2500 mV center, and 1 selects the `track_i` sample as center.
- R3: Configuration bit 1 selects the half-width. 0 gives 220 mV and 1 gives 720 mV.
- R4: The upper limit saturates at full scale (2^SAMPLE_W-1), and the lower limit saturates at zero.
- R5: While `run_phase_i` is 0, no fault can be raised, and the filter timer returns to idle.
- R6: The fault is set on the clock edge that samples the violation for the (CHARGE_CYC+DECAY_CYC+1)-th consecutive time. It is then visible after that edge.
- R7: If the violation disappears during the charge interval, the timer resets. If it disappears during the decay interval, the timer runs on, and only the violation at the final decay cycle decides the outcome.
- R8: `lamp_absent_o` goes high one cycle after a sample above 4630 mV. It goes low one cycle after a sample below 4470 mV. Between those two levels it holds its value.
- R9: `relamp_o` pulses high for exactly one cycle, on the same edge at which `lamp_absent_o` falls.
- R10: A set fault holds until `fault_clr_i` is sampled high or a re-lamp occurs. A clear and a set on the same edge resolve to clear, and a clear also restarts the timer.
- R11: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_phase_i | input | 1 | 1 = run phase (window active), 0 = ignition (window blanked) |
| cfg_i | input | 2 | Bit 0 selects the tracking center, bit 1 selects the wide half-width |
| fault_clr_i | input | 1 | Clears the latched fault |
| sense_i | input | SAMPLE_W | Lamp-sense sample in mV |
| track_i | input | SAMPLE_W | Bus-proportional center sample in mV |
| eol_fault_o | output | 1 | Latched end-of-life fault |
| lamp_absent_o | output | 1 | Lamp missing, with hysteresis |
| relamp_o | output | 1 | One-cycle re-lamp event |

## Verification
Two things can land on the same clock edge: the final decay cycle that would latch the fault, and a clear, which comes either from `fault_clr_i` or from a re-lamp release. The bench provokes this by holding a violation for exactly the full filter length and raising the clear on the last of those cycles. The fault must stay low, and the timer must restart from idle. The behavioural model applies the same clear-over-set rule on every clock. A further case latches the fault first, then runs an absence and release sequence while blanked, and checks that the fault drops on the same edge as the re-lamp pulse.

// File: rtl/eol_pkg.sv
package eol_pkg;
    typedef enum logic [1:0] {
        TMR_IDLE   = 2'd0,
        TMR_CHARGE = 2'd1,
        TMR_DECAY  = 2'd2
    } tmr_state_e;

    localparam int CFG_TRACK_BIT = 0;
    localparam int CFG_WIDE_BIT  = 1;
endpackage

// File: rtl/eol_window_calc.sv
module eol_window_calc #(
    parameter int SAMPLE_W     = 13,
    parameter int FIXED_CTR_MV = 2500,
    parameter int HALF_NAR_MV  = 220,
    parameter int HALF_WIDE_MV = 720
) (
    input  logic [1:0]          cfg_i,
    input  logic [SAMPLE_W-1:0] sense_i,
    input  logic [SAMPLE_W-1:0] track_i,
    output logic                viol_o
);
    import eol_pkg::*;

    localparam int XW = SAMPLE_W + 1;
    localparam logic [XW-1:0] FULL_SCALE = XW'((1 << SAMPLE_W) - 1);
    localparam logic [XW-1:0] FIXED_CTR  = XW'(FIXED_CTR_MV);
    localparam logic [XW-1:0] HALF_NAR   = XW'(HALF_NAR_MV);
    localparam logic [XW-1:0] HALF_WIDE  = XW'(HALF_WIDE_MV);

    logic [XW-1:0] center_x;
    logic [XW-1:0] half_x;
    logic [XW-1:0] sum_x;
    logic [XW-1:0] upper_x;
    logic [XW-1:0] lower_x;
    logic [XW-1:0] sense_x;

    always_comb begin
        center_x = cfg_i[CFG_TRACK_BIT] ? {1'b0, track_i} : FIXED_CTR;
        half_x   = cfg_i[CFG_WIDE_BIT] ? HALF_WIDE : HALF_NAR;
        sum_x    = center_x + half_x;
        upper_x  = (sum_x > FULL_SCALE) ? FULL_SCALE : sum_x;
        lower_x  = (center_x >= half_x) ? (center_x - half_x) : '0;
        sense_x  = {1'b0, sense_i};
        viol_o   = (sense_x > upper_x) || (sense_x < lower_x);
    end
endmodule

// File: rtl/eol_fault_timer.sv
module eol_fault_timer #(
    parameter int CHARGE_CYC = 4000,
    parameter int DECAY_CYC  = 6000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic restart_i,
    input  logic viol_i,
    output logic fire_o
);
    import eol_pkg::*;

    localparam int MAX_CYC = (CHARGE_CYC > DECAY_CYC) ? CHARGE_CYC : DECAY_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] CHARGE_LIM = CNT_W'(CHARGE_CYC);
    localparam logic [CNT_W-1:0] DECAY_LIM  = CNT_W'(DECAY_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);

    typedef struct packed {
        tmr_state_e       st;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        fire_o = 1'b0;
        if (!enable_i || restart_i) begin
            tmr_d.st  = TMR_IDLE;
            tmr_d.cnt = '0;
        end else begin
            case (tmr_q.st)
                TMR_IDLE: begin
                    if (viol_i) begin
                        tmr_d.st  = TMR_CHARGE;
                        tmr_d.cnt = CNT_ONE;
                    end
                end
                TMR_CHARGE: begin
                    if (!viol_i) begin
                        tmr_d.st  = TMR_IDLE;
                        tmr_d.cnt = '0;
                    end else if (tmr_q.cnt == CHARGE_LIM) begin
                        tmr_d.st  = TMR_DECAY;
                        tmr_d.cnt = CNT_ONE;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + CNT_ONE;
                    end
                end
                TMR_DECAY: begin
                    if (tmr_q.cnt == DECAY_LIM) begin
                        fire_o    = viol_i;
                        tmr_d.st  = TMR_IDLE;
                        tmr_d.cnt = '0;
                    end else begin
                        tmr_d.cnt = tmr_q.cnt + CNT_ONE;
                    end
                end
                default: begin
                    tmr_d.st  = TMR_IDLE;
                    tmr_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q.st  <= TMR_IDLE;
            tmr_q.cnt <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/eol_absence_det.sv
module eol_absence_det #(
    parameter int SAMPLE_W   = 13,
    parameter int SET_MV     = 4630,
    parameter int HYST_MV    = 160
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [SAMPLE_W-1:0] sense_i,
    output logic                absent_o,
    output logic                relamp_o,
    output logic                release_o
);
    localparam int REL_MV = (SET_MV > HYST_MV) ? (SET_MV - HYST_MV) : 0;
    localparam logic [SAMPLE_W-1:0] SET_V = SAMPLE_W'(SET_MV);
    localparam logic [SAMPLE_W-1:0] REL_V = SAMPLE_W'(REL_MV);

    typedef struct packed {
        logic absent;
        logic relamp;
    } abs_s;

    abs_s abs_d, abs_q;

    always_comb begin
        release_o     = abs_q.absent && (sense_i < REL_V);
        abs_d.absent  = abs_q.absent ? !release_o : (sense_i > SET_V);
        abs_d.relamp  = release_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            abs_q <= '0;
        end else begin
            abs_q <= abs_d;
        end
    end

    assign absent_o = abs_q.absent;
    assign relamp_o = abs_q.relamp;
endmodule

// File: rtl/eol_window_monitor.sv
module eol_window_monitor #(
    parameter int SAMPLE_W       = 13,
    parameter int FIXED_CTR_MV   = 2500,
    parameter int HALF_NAR_MV    = 220,
    parameter int HALF_WIDE_MV   = 720,
    parameter int ABSENT_SET_MV  = 4630,
    parameter int ABSENT_HYST_MV = 160,
    parameter int CHARGE_CYC     = 4000,
    parameter int DECAY_CYC      = 6000
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_phase_i,
    input  logic [1:0]          cfg_i,
    input  logic                fault_clr_i,
    input  logic [SAMPLE_W-1:0] sense_i,
    input  logic [SAMPLE_W-1:0] track_i,
    output logic                eol_fault_o,
    output logic                lamp_absent_o,
    output logic                relamp_o
);
    logic viol_w;
    logic fire_w;
    logic release_w;
    logic clear_w;
    logic fault_d, fault_q;

    eol_window_calc #(
        .SAMPLE_W    (SAMPLE_W),
        .FIXED_CTR_MV(FIXED_CTR_MV),
        .HALF_NAR_MV (HALF_NAR_MV),
        .HALF_WIDE_MV(HALF_WIDE_MV)
    ) u_calc (
        .cfg_i  (cfg_i),
        .sense_i(sense_i),
        .track_i(track_i),
        .viol_o (viol_w)
    );

    eol_absence_det #(
        .SAMPLE_W(SAMPLE_W),
        .SET_MV  (ABSENT_SET_MV),
        .HYST_MV (ABSENT_HYST_MV)
    ) u_absence (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sense_i  (sense_i),
        .absent_o (lamp_absent_o),
        .relamp_o (relamp_o),
        .release_o(release_w)
    );

    assign clear_w = fault_clr_i || release_w;

    eol_fault_timer #(
        .CHARGE_CYC(CHARGE_CYC),
        .DECAY_CYC (DECAY_CYC)
    ) u_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (run_phase_i),
        .restart_i(clear_w),
        .viol_i   (viol_w),
        .fire_o   (fire_w)
    );

    always_comb begin
        fault_d = fault_q;
        if (clear_w) begin
            fault_d = 1'b0;
        end else if (fire_w) begin
            fault_d = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fault_q <= 1'b0;
        end else begin
            fault_q <= fault_d;
        end
    end

    assign eol_fault_o = fault_q;
endmodule

// File: rtl/eol_window_monitor_chk.sv
module eol_window_monitor_chk #(
    parameter int SAMPLE_W      = 13,
    parameter int ABSENT_SET_MV = 4630
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                run_phase_i,
    input logic                fault_clr_i,
    input logic [SAMPLE_W-1:0] sense_i,
    input logic                viol_w,
    input logic                eol_fault_o,
    input logic                lamp_absent_o,
    input logic                relamp_o
);
    localparam logic [SAMPLE_W-1:0] SET_V = SAMPLE_W'(ABSENT_SET_MV);

    AST_FAULT_NEEDS_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(eol_fault_o) |-> $past(viol_w)); // R1

    AST_FAULT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(eol_fault_o) |-> $past(run_phase_i)); // R5

    AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(fault_clr_i) |-> !eol_fault_o); // R10

    AST_FAULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(eol_fault_o) |-> ($past(fault_clr_i) || relamp_o)); // R10

    AST_ABSENT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lamp_absent_o) |-> ($past(sense_i) > SET_V)); // R8

    AST_RELAMP_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        relamp_o |-> (!lamp_absent_o && $past(lamp_absent_o))); // R9

    AST_RELAMP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        relamp_o |=> !relamp_o); // R9
endmodule

bind eol_window_monitor eol_window_monitor_chk #(
    .SAMPLE_W     (SAMPLE_W),
    .ABSENT_SET_MV(ABSENT_SET_MV)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_phase_i  (run_phase_i),
    .fault_clr_i  (fault_clr_i),
    .sense_i      (sense_i),
    .viol_w       (viol_w),
    .eol_fault_o  (eol_fault_o),
    .lamp_absent_o(lamp_absent_o),
    .relamp_o     (relamp_o)
);

// File: tb/eol_window_monitor_tb.sv
`timescale 1ns/1ps
module eol_window_monitor_tb;
    localparam int W  = 13;
    localparam int NC = 8;
    localparam int ND = 12;
    localparam int FS = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run = 1'b1;
    logic [1:0]   cfg = 2'b00;
    logic         clr = 1'b0;
    logic [W-1:0] sense = W'(2500);
    logic [W-1:0] track = W'(2500);
    logic         fault, absent, relamp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    int m_e = 0;
    bit m_fault = 0, m_abs = 0, m_rel = 0;

    always #2.5 clk = ~clk;

    eol_window_monitor #(
        .SAMPLE_W  (W),
        .CHARGE_CYC(NC),
        .DECAY_CYC (ND)
    ) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .run_phase_i  (run),
        .cfg_i        (cfg),
        .fault_clr_i  (clr),
        .sense_i      (sense),
        .track_i      (track),
        .eol_fault_o  (fault),
        .lamp_absent_o(absent),
        .relamp_o     (relamp)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit ref_viol();
        int c, h, hi, lo, s;
        s  = int'(sense);
        c  = cfg[0] ? int'(track) : 2500;
        h  = cfg[1] ? 720 : 220;
        hi = (c + h > FS) ? FS : c + h;
        lo = (c < h) ? 0 : c - h;
        return (s > hi) || (s < lo);
    endfunction

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_e = 0; m_fault = 0; m_abs = 0; m_rel = 0;
        end else begin
            bit v, rls, clear, fire;
            v     = ref_viol();
            rls   = m_abs && (int'(sense) < 4470);
            clear = clr || rls;
            fire  = 0;
            if (!run || clear) begin
                m_e = 0;
            end else if (m_e == 0) begin
                m_e = v ? 1 : 0;
            end else if (m_e <= NC) begin
                m_e = v ? m_e + 1 : 0;
            end else if (m_e < NC + ND) begin
                m_e = m_e + 1;
            end else begin
                fire = v;
                m_e  = 0;
            end
            m_fault = clear ? 0 : (fire ? 1 : m_fault);
            m_rel   = rls;
            m_abs   = m_abs ? !rls : (int'(sense) > 4630);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 model fault", fault, m_fault);
            chk("R8 model absent", absent, m_abs);
            chk("R9 model relamp", relamp, m_rel);
        end
    end

    task automatic hold(input int s, input int n);
        sense = W'(s);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_fault(input int s);
        clr = 1'b1;
        hold(s, 1);
        clr = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 fault in reset", fault, 1'b0);
        chk("R11 absent in reset", absent, 1'b0);
        chk("R11 relamp in reset", relamp, 1'b0);
        rst_n = 1'b1;
        hold(2500, 2);

        // fixed narrow window, upper side and filter length
        cfg = 2'b00;
        hold(2721, NC + ND);
        chk("R6 before full cycle", fault, 1'b0);
        hold(2721, 1);
        chk("R6 after full cycle", fault, 1'b1);
        hold(2500, 5);
        chk("R10 fault holds", fault, 1'b1);
        clear_fault(2500);
        chk("R10 explicit clear", fault, 1'b0);
        hold(2720, 30);
        chk("R3 upper edge inside", fault, 1'b0);
        hold(2280, 30);
        chk("R1 lower edge inside", fault, 1'b0);
        hold(2279, NC + ND + 1);
        chk("R1 below window", fault, 1'b1);
        clear_fault(2500);

        // fixed wide window
        cfg = 2'b10;
        hold(3220, 30);
        chk("R3 wide upper inside", fault, 1'b0);
        hold(1779, NC + ND + 1);
        chk("R3 wide lower outside", fault, 1'b1);
        clear_fault(2500);

        // tracking narrow window
        cfg = 2'b01;
        track = W'(3000);
        hold(2900, 30);
        chk("R2 tracking center used", fault, 1'b0);
        hold(3221, NC + ND + 1);
        chk("R2 tracking upper outside", fault, 1'b1);
        clear_fault(3000);

        // saturation
        cfg = 2'b11;
        track = W'(100);
        hold(0, 30);
        chk("R4 floor at zero", fault, 1'b0);
        track = W'(8000);
        hold(8191, 30);
        chk("R4 ceiling at full scale", fault, 1'b0);
        chk("R8 absent at full scale", absent, 1'b1);
        hold(7000, NC + ND + 1);
        chk("R4 below saturated window", fault, 1'b1);
        track = W'(2500);
        hold(2500, 1);
        chk("R9 release pulse", relamp, 1'b1);
        chk("R10 relamp clears fault", fault, 1'b0);
        hold(2500, 2);

        // blanking
        cfg = 2'b00;
        run = 1'b0;
        hold(4000, 30);
        chk("R5 blanked no fault", fault, 1'b0);
        run = 1'b1;
        hold(4000, 10);
        run = 1'b0;
        hold(4000, 1);
        run = 1'b1;
        hold(4000, NC + ND);
        chk("R5 blank restarts timer", fault, 1'b0);
        hold(4000, 1);
        chk("R5 full cycle after blank", fault, 1'b1);
        clear_fault(2500);

        // gaps in charge and decay
        hold(2800, 5);
        hold(2500, 1);
        hold(2800, NC + ND);
        chk("R7 charge gap restarts", fault, 1'b0);
        hold(2800, 1);
        chk("R7 fires after restart", fault, 1'b1);
        clear_fault(2500);
        hold(2800, NC + 1);
        hold(2500, ND - 1);
        hold(2800, 1);
        chk("R7 decay gap ignored", fault, 1'b1);
        clear_fault(2500);
        hold(2800, NC + 1);
        hold(2500, ND);
        chk("R7 absent at decay end", fault, 1'b0);
        hold(2500, 10);
        chk("R7 stays clear", fault, 1'b0);

        // clear and set on the same edge
        hold(2800, NC + ND);
        clr = 1'b1;
        hold(2800, 1);
        clr = 1'b0;
        chk("R10 clear beats set", fault, 1'b0);
        hold(2500, 2);

        // absence hysteresis and re-lamp clearing a fault
        hold(2800, NC + ND + 1);
        chk("R6 fault before relamp", fault, 1'b1);
        run = 1'b0;
        hold(4630, 2);
        chk("R8 at threshold not absent", absent, 1'b0);
        hold(4631, 1);
        chk("R8 above threshold absent", absent, 1'b1);
        hold(4470, 3);
        chk("R8 hysteresis holds", absent, 1'b1);
        chk("R9 no pulse while held", relamp, 1'b0);
        hold(4469, 1);
        chk("R8 released", absent, 1'b0);
        chk("R9 pulse on release", relamp, 1'b1);
        chk("R10 relamp clears fault", fault, 1'b0);
        hold(2500, 1);
        chk("R9 pulse single cycle", relamp, 1'b0);
        run = 1'b1;
        hold(2500, 5);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule